// File: doc/BRIEF.md
# Byte-Addressed Serial-Bus Memory Slave with Write Protection

This block is a two-wire serial-bus (I2C) target that gives an external bus master read and write access to a small on-chip byte memory. It observes the open-drain clock and data lines through input samples and only ever pulls the data line low through an output-enable. The pad returns to high through the external pull-up. Both line samples pass through a synchroniser on the system clock, which must run at least 8 times faster than the bus clock. Start, repeated start and stop conditions are decoded from those samples.

A transaction opens with a 7-bit device address and a direction bit. The upper four address bits come from a parameter and the lower three come from strap pins. In a write, the first data byte sets the internal word pointer and each later byte is stored at that pointer, which then advances. In a read, bytes are shifted out from the pointer onward for as long as the master acknowledges. An active-high write-protect input refuses stores. A parameter chooses whether protection covers the whole array or only its upper half.

Top module: `i2cProtMem`

## Requirements
- R1: A falling data line while the clock is high (start) is recognised in any state, including in the middle of a byte. It discards the partial byte, stores nothing and makes the block expect a new device-address byte. A repeated start behaves identically.
- R2: A rising data line while the clock is high (stop) releases the data line and returns the block to idle. Later bytes are neither acknowledged nor acted on until the next start.
- R3: The block never drives a line high. The data line is only pulled low through `sdaOe`, which is 0 after reset and only becomes 1 while the synchronised clock is low.
- R4: An address byte whose upper seven bits (MSB first) equal {DEV_HI, devPins[2:0]} is acknowledged by holding data low during the ninth clock. Its last bit selects the direction: 1 = read, 0 = write.
- R5: An address byte that does not match is not acknowledged, and every later byte is ignored until the next start.
- R6: In a write, the first data byte loads the word pointer and is acknowledged. Each later byte is stored at the pointer and acknowledged, and the pointer then advances by one, wrapping from 255 to 0.
- R7: While `wp` is 1, a data byte aimed at a protected location is not acknowledged, is not stored, and leaves the pointer unchanged. With PROT_HALF = 0 every location is protected. With PROT_HALF = 1 only locations 128 to 255 are protected. The word-pointer byte is always accepted.
- R8: A read shifts out the byte at the pointer MSB first and advances the pointer, wrapping at 255. Another byte follows while the master pulls data low in the ninth clock. After a master no-acknowledge, the block releases data and returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| devPins | input | 3 | Low three bits of the device address |
| wp | input | 1 | Active-high write protect |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
Two instances with different strap pins share one open-drain bus, one protecting the whole array and one protecting only the upper half. Every address byte is therefore also a non-match for the other instance. A vector table writes single bytes with protection off and on, to lower-half, upper-half and boundary (127/128) locations, and reads each one back. A refused store then shows up as the old value, and the halves are told apart per variant. Directed sequences cover a burst that wraps from 255 to 0, read with master acknowledges and a final no-acknowledge, a repeated start that cuts a data byte short, a byte clocked after a stop, and a foreign device address.

// File: rtl/i2cProtMemPkg.sv
package i2cProtMemPkg;

  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadWordAddr;
    logic storeByte;
    logic incAddr;
    logic loadTx;
    logic shiftTx;
  } memStrobe_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] sclPipe;
  logic [PW-1:0] sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PW-2:0], sclIn};
      sdaPipe <= {sdaPipe[PW-2:0], sdaIn};
    end
  end

  logic sclP, sdaP;
  assign sclS = sclPipe[PW-2];
  assign sdaS = sdaPipe[PW-2];
  assign sclP = sclPipe[PW-1];
  assign sdaP = sdaPipe[PW-1];

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
endmodule

// File: rtl/i2cMemData.sv
module i2cMemData
  import i2cProtMemPkg::*;
#(
  parameter int         AW        = 8,
  parameter logic [3:0] DEV_HI    = 4'b1010,
  parameter bit         PROT_HALF = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  memStrobe_t    stb,
  input  logic          sdaBit,
  input  logic [2:0]    devPins,
  input  logic          wp,
  output logic          addrHit,
  output logic          rwBit,
  output logic          writeBlocked,
  output logic          txMsb,
  output logic [AW-1:0] wordAddr
);
  localparam int DEPTH = 1 << AW;

  logic [BYTE_BITS-1:0] mem [DEPTH];
  logic [BYTE_BITS-1:0] rxShift;
  logic [BYTE_BITS-1:0] txShift;
  logic                 inRegion;

  generate
    if (PROT_HALF) begin : gUpperHalf
      assign inRegion = wordAddr[AW-1];
    end else begin : gWhole
      assign inRegion = 1'b1;
    end
  endgenerate

  assign writeBlocked = wp & inRegion;
  assign addrHit      = (rxShift[BYTE_BITS-1:1] == {DEV_HI, devPins});
  assign rwBit        = rxShift[0];
  assign txMsb        = txShift[BYTE_BITS-1];

  always_ff @(posedge clk) begin
    if (stb.storeByte) mem[wordAddr] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '1;
      wordAddr <= '0;
    end else begin
      if (stb.shiftIn)           rxShift  <= {rxShift[BYTE_BITS-2:0], sdaBit};
      if (stb.loadWordAddr)      wordAddr <= rxShift[AW-1:0];
      else if (stb.incAddr)      wordAddr <= wordAddr + 1'b1;
      if (stb.loadTx)            txShift  <= mem[wordAddr];
      else if (stb.shiftTx)      txShift  <= {txShift[BYTE_BITS-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/i2cMemCtrl.sv
module i2cMemCtrl
  import i2cProtMemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaBit,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       addrHit,
  input  logic       rwBit,
  input  logic       writeBlocked,
  input  logic       txMsb,
  output memStrobe_t stb,
  output busState_t  state,
  output logic       sdaOe
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  busState_t        stateN, afterAck, afterN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic             ackOn, ackN, masterAck, mackN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      afterAck  <= ST_IDLE;
      bitCnt    <= '0;
      ackOn     <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateN;
      afterAck  <= afterN;
      bitCnt    <= cntN;
      ackOn     <= ackN;
      masterAck <= mackN;
    end
  end

  always_comb begin
    stateN = state;
    afterN = afterAck;
    cntN   = bitCnt;
    ackN   = ackOn;
    mackN  = masterAck;
    stb    = '0;
    if (stopDet) begin
      stateN = ST_IDLE;
      ackN   = 1'b0;
    end else if (startDet) begin
      stateN = ST_ADDR;
      cntN   = '0;
      ackN   = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WADDR, ST_WDATA: begin
          if (sclRise && bitCnt != FULL) begin
            stb.shiftIn = 1'b1;
            cntN        = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            stateN = ST_ACK;
            ackN   = 1'b1;
            afterN = ST_WDATA;
            if (state == ST_ADDR) begin
              if (addrHit) begin
                afterN = rwBit ? ST_RDATA : ST_WADDR;
              end else begin
                stateN = ST_IGNORE;
                ackN   = 1'b0;
              end
            end else if (state == ST_WADDR) begin
              stb.loadWordAddr = 1'b1;
            end else if (writeBlocked) begin
              ackN = 1'b0;
            end else begin
              stb.storeByte = 1'b1;
              stb.incAddr   = 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stateN = afterAck;
            cntN   = '0;
            ackN   = 1'b0;
            if (afterAck == ST_RDATA) stb.loadTx = 1'b1;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            cntN = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              stateN      = ST_RACK;
              stb.incAddr = 1'b1;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mackN = ~sdaBit;
          end else if (sclFall) begin
            if (masterAck) begin
              stateN     = ST_RDATA;
              cntN       = '0;
              stb.loadTx = 1'b1;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACK && ackOn) || (state == ST_RDATA && !txMsb);
endmodule

// File: rtl/i2cProtMem.sv
module i2cProtMem
  import i2cProtMemPkg::*;
#(
  parameter int         AW          = 8,
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter bit         PROT_HALF   = 1'b0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] devPins,
  input  logic       wp,
  output logic       sdaOe
);
  logic          sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic          addrHit, rwBit, writeBlocked, txMsb;
  logic [AW-1:0] wordAddr;
  memStrobe_t    stb;
  busState_t     state;

  i2cLineSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cMemCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaBit(sdaS), .startDet(startDet), .stopDet(stopDet),
    .addrHit(addrHit), .rwBit(rwBit), .writeBlocked(writeBlocked),
    .txMsb(txMsb), .stb(stb), .state(state), .sdaOe(sdaOe)
  );

  i2cMemData #(.AW(AW), .DEV_HI(DEV_HI), .PROT_HALF(PROT_HALF)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaS),
    .devPins(devPins), .wp(wp), .addrHit(addrHit), .rwBit(rwBit),
    .writeBlocked(writeBlocked), .txMsb(txMsb), .wordAddr(wordAddr)
  );
endmodule

// File: rtl/i2cProtMemChk.sv
module i2cProtMemChk
  import i2cProtMemPkg::*;
#(
  parameter int AW        = 8,
  parameter bit PROT_HALF = 1'b0
) (
  input logic          clk,
  input logic          rstN,
  input logic          sdaOe,
  input logic          sclS,
  input logic          startDet,
  input logic          stopDet,
  input logic          wp,
  input logic [AW-1:0] wordAddr,
  input memStrobe_t    stb,
  input busState_t     state
);
  logic protHere;
  assign protHere = PROT_HALF ? wordAddr[AW-1] : 1'b1;

  assert_start_resync_R1: assert property (@(posedge clk) disable iff (!rstN)
    startDet && !stopDet |=> state == ST_ADDR);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaOe));

  assert_drive_low_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  assert_one_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.loadWordAddr, stb.storeByte, stb.loadTx, stb.shiftTx}));

  assert_no_protected_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeByte |-> !(wp && protHere));

  assert_master_ack_slot_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_RACK |-> !sdaOe);
endmodule

bind i2cProtMem i2cProtMemChk #(.AW(AW), .PROT_HALF(PROT_HALF)) uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclS(sclS),
  .startDet(startDet), .stopDet(stopDet), .wp(wp),
  .wordAddr(wordAddr), .stb(stb), .state(state)
);

// File: tb/sim_i2cProtMem.sv
`timescale 1ns/1ps
module sim_i2cProtMem;
  localparam int Q = 5;
  localparam logic [6:0] DEV0 = 7'b1010001;
  localparam logic [6:0] DEV1 = 7'b1010010;

  // {dev, wp, addr[7:0], data[7:0], expAck, expRead[7:0]}; dev 0 = whole-array protect, 1 = upper-half protect
  localparam logic [26:0] VEC [0:10] = '{
    {1'b0, 1'b0, 8'h10, 8'hA5, 1'b1, 8'hA5},
    {1'b0, 1'b1, 8'h10, 8'h3C, 1'b0, 8'hA5},
    {1'b0, 1'b0, 8'h90, 8'h5A, 1'b1, 8'h5A},
    {1'b0, 1'b1, 8'h90, 8'h00, 1'b0, 8'h5A},
    {1'b1, 1'b0, 8'h20, 8'h11, 1'b1, 8'h11},
    {1'b1, 1'b1, 8'h20, 8'h22, 1'b1, 8'h22},
    {1'b1, 1'b0, 8'hC0, 8'h77, 1'b1, 8'h77},
    {1'b1, 1'b1, 8'hC0, 8'h88, 1'b0, 8'h77},
    {1'b1, 1'b1, 8'h7F, 8'h99, 1'b1, 8'h99},
    {1'b1, 1'b0, 8'h80, 8'h66, 1'b1, 8'h66},
    {1'b1, 1'b1, 8'h80, 8'h44, 1'b0, 8'h66}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic wp = 1'b0;
  logic sdaOe0, sdaOe1;
  logic sdaBus;
  int   checks = 0;
  int   fails = 0;

  always #10 clk = ~clk;
  assign sdaBus = ~(mLow | sdaOe0 | sdaOe1);

  i2cProtMem #(.PROT_HALF(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .devPins(3'b001), .wp(wp), .sdaOe(sdaOe0));

  i2cProtMem #(.PROT_HALF(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus),
    .devPins(3'b010), .wp(wp), .sdaOe(sdaOe1));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    waitQ(1); mLow = 1'b0;
    waitQ(1); scl = 1'b1;
    waitQ(1); mLow = 1'b1;
    waitQ(1); scl = 1'b0;
  endtask

  task automatic busStop();
    waitQ(1); mLow = 1'b1;
    waitQ(1); scl = 1'b1;
    waitQ(1); mLow = 1'b0;
    waitQ(2);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      waitQ(1); mLow = ~b[i];
      waitQ(1); scl = 1'b1;
      waitQ(2); scl = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    waitQ(1); mLow = 1'b0;
    waitQ(1); scl = 1'b1;
    waitQ(1); ack = ~sdaBus;
    waitQ(1); scl = 1'b0;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      waitQ(1); mLow = 1'b0;
      waitQ(1); scl = 1'b1;
      waitQ(1); b[i] = sdaBus;
      waitQ(1); scl = 1'b0;
    end
    waitQ(1); mLow = mAck;
    waitQ(1); scl = 1'b1;
    waitQ(2); scl = 1'b0;
  endtask

  task automatic writeAt(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                         output logic ackA, output logic ackD);
    logic ackW;
    busStart();
    sendByte({dev, 1'b0}, ackA);
    sendByte(a, ackW);
    sendByte(d, ackD);
    busStop();
  endtask

  task automatic readAt(input logic [6:0] dev, input logic [7:0] a, output logic ackA,
                        output logic [7:0] d);
    logic ackW, ackR;
    busStart();
    sendByte({dev, 1'b0}, ackA);
    sendByte(a, ackW);
    busStart();
    sendByte({dev, 1'b1}, ackR);
    readByte(1'b0, d);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic ackA, ackD, ackX;
    logic [7:0] rd, rd1, rd2;
    logic [6:0] dev;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R3: both targets release the data line after reset
    check(!sdaOe0 && !sdaOe1 && sdaBus, "R3 reset release", {6'd0, sdaOe1, sdaOe0}, 8'h00);

    for (int k = 0; k < 11; k++) begin
      dev = VEC[k][26] ? DEV1 : DEV0;
      wp  = VEC[k][25];
      writeAt(dev, VEC[k][24:17], VEC[k][16:9], ackA, ackD);
      wp  = 1'b0;
      check(ackA, "R4 address ack", {7'd0, ackA}, 8'h01);
      check(ackD == VEC[k][8], VEC[k][25] ? "R7 protect ack" : "R6 write ack",
            {7'd0, ackD}, {7'd0, VEC[k][8]});
      readAt(dev, VEC[k][24:17], ackA, rd);
      check(rd == VEC[k][7:0], VEC[k][25] ? "R7 readback" : "R6 readback", rd, VEC[k][7:0]);
    end

    // R6: burst write crossing the top of the array
    busStart();
    sendByte({DEV0, 1'b0}, ackA);
    sendByte(8'hFE, ackX);
    sendByte(8'hD0, ackD);
    sendByte(8'hD1, ackD);
    sendByte(8'hD2, ackD);
    check(ackD, "R6 wrap write ack", {7'd0, ackD}, 8'h01);
    busStop();

    // R8: sequential read with master acks, wrapping 0xFF -> 0x00
    busStart();
    sendByte({DEV0, 1'b0}, ackA);
    sendByte(8'hFE, ackX);
    busStart();
    sendByte({DEV0, 1'b1}, ackA);
    readByte(1'b1, rd);
    readByte(1'b1, rd1);
    readByte(1'b0, rd2);
    check(rd == 8'hD0, "R8 seq byte0", rd, 8'hD0);
    check(rd1 == 8'hD1, "R8 seq byte1", rd1, 8'hD1);
    check(rd2 == 8'hD2, "R6 R8 wrapped byte", rd2, 8'hD2);
    repeat (8) @(negedge clk);
    check(!sdaOe0, "R8 release after nack", {7'd0, sdaOe0}, 8'h00);
    busStop();

    // R1: repeated start in the middle of a data byte discards it
    busStart();
    sendByte({DEV0, 1'b0}, ackA);
    sendByte(8'h10, ackX);
    sendBits(8'h00, 4);
    busStart();
    sendByte({DEV0, 1'b1}, ackA);
    check(ackA, "R1 address after restart", {7'd0, ackA}, 8'h01);
    readByte(1'b0, rd);
    check(rd == 8'hA5, "R1 partial byte not stored", rd, 8'hA5);
    busStop();

    // R2: after a stop, a byte without a start is not acknowledged
    sendByte({DEV0, 1'b0}, ackA);
    check(!ackA, "R2 ignored after stop", {7'd0, ackA}, 8'h00);

    // R5: foreign address, nothing answers the address or the next byte
    busStart();
    sendByte({7'b1010111, 1'b0}, ackA);
    sendByte(8'h10, ackX);
    check(!ackA, "R5 foreign address nack", {7'd0, ackA}, 8'h00);
    check(!ackX, "R5 following byte ignored", {7'd0, ackX}, 8'h00);
    busStop();
    readAt(DEV0, 8'h10, ackA, rd);
    check(rd == 8'hA5, "R5 memory untouched", rd, 8'hA5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule